// File: doc/BRIEF.md
# Packed SIMD Fixed-Point Multiply Unit

This block is the multiply datapath of a 32-bit signal-processing core. Each cycle it can accept two 32-bit operands and an operation code. The code selects one of these forms:

- a four-lane byte dot product
- lane-packed multiplies of signed 16-bit lanes and of 8-bit lanes
- a halfword-by-word multiply, either at full width or rounded down to 32 bits
- a doubled multiply of 16-bit lanes with saturation

The answer comes back as two 32-bit words, `res_hi` and `res_lo`. Operations that yield one 32-bit value place it in `res_lo` and drive `res_hi` to zero.

The arithmetic is combinational. A fixed pipeline of `LATENCY` register stages follows it and carries the data together with a valid flag. Issue is fully pipelined, so a new operation may enter on every cycle. Its result appears exactly `LATENCY` clock edges after the edge that captured it.

Top module: `simd_mpy_unit`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, and on the first cycle after it is released, `valid_out` is 0 and both result words are 0, whatever `valid_in` does during reset.
- R2: `valid_out` rises exactly `LATENCY` rising edges after the edge that samples `valid_in` high. Back-to-back issues come out back-to-back, one result per issue.
- R3: Whenever `valid_out` is 0, `res_hi` and `res_lo` are both 0.
- R4: Opcode 0 (byte dot product) treats every byte as unsigned. It multiplies byte i of `src1` by byte i of `src2` for i = 0..3, puts the 32-bit sum of the four products in `res_lo`, and drives `res_hi` to 0.
- R5: Opcode 1 (dual signed 16-bit multiply) puts `src1[31:16]*src2[31:16]` in `res_hi` and `src1[15:0]*src2[15:0]` in `res_lo`. Every halfword is two's complement and each product is the full 32-bit value.
- R6: Opcodes 2 and 3 multiply a signed halfword of `src1` by the whole signed `src2`. Opcode 2 uses bits 31:16 and opcode 3 uses bits 15:0. The 48-bit product, sign-extended to 64 bits, appears as `{res_hi, res_lo}`.
- R7: Opcodes 4 and 5 use the same products as opcodes 2 and 3 respectively. They add 0x4000 to the product, shift it arithmetically right by 15, and put the low 32 bits in `res_lo`. `res_hi` is 0.
- R8: Opcode 6 (doubled multiply) computes the signed product of each 16-bit lane pair and shifts it left by one bit. The upper lanes go to `res_hi` and the lower lanes to `res_lo`. A lane whose two inputs are both 0x8000 yields 0x7FFFFFFF.
- R9: Opcode 7 multiplies each signed byte of `src1` by the unsigned byte of `src2` in the same lane, giving a 16-bit product per lane. Lane 3 goes to `res_hi[31:16]`, lane 2 to `res_hi[15:0]`, lane 1 to `res_lo[31:16]` and lane 0 to `res_lo[15:0]`.
- R10: Opcode 8 performs the same four-lane byte multiply and placement as R9, with both operands unsigned.
- R11: Opcodes 9 to 15 are unassigned. Such an issue still produces a `valid_out` pulse after `LATENCY` cycles, with both result words 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Issue strobe for the operands and opcode of this cycle |
| opcode | input | 4 | Operation select (encodings in R4 to R11) |
| src1 | input | 32 | First operand |
| src2 | input | 32 | Second operand |
| valid_out | output | 1 | Result words carry a finished operation |
| res_hi | output | 32 | Upper result word |
| res_lo | output | 32 | Lower result word, or the single 32-bit result |

## Verification
The bench builds the unit with its default `LATENCY` of 4. This depth is long enough that up to four operations are in flight at once. The random stream, which has gaps in `valid_in`, therefore mixes opcodes inside the pipeline and exposes any stage that leaks data or drops a valid flag. Operand bytes are biased toward 0x80, 0x7F, 0x00 and 0xFF, so saturation, sign extension and rounding near the carry boundary turn up often among the random cases as well as in the directed ones.

// File: rtl/simd_mpy_pkg.sv
package simd_mpy_pkg;
  localparam int WORD = 32;
  localparam int HALF = WORD / 2;
  localparam int BYTE = 8;
  localparam int NBYTE = WORD / BYTE;
  localparam int NHALF = WORD / HALF;
  localparam int OP_W = 4;
  localparam int RND_SH = 15;

  typedef enum logic [OP_W-1:0] {
    OP_DOT4U   = 4'd0,
    OP_MUL2S   = 4'd1,
    OP_HWH     = 4'd2,
    OP_HWL     = 4'd3,
    OP_HWH_RND = 4'd4,
    OP_HWL_RND = 4'd5,
    OP_MUL2DS  = 4'd6,
    OP_MUL4SU  = 4'd7,
    OP_MUL4U   = 4'd8
  } mpy_op_e;

  function automatic logic [WORD-1:0] f_dot4u(input logic [WORD-1:0] a, input logic [WORD-1:0] b);
    logic [WORD-1:0] acc;
    acc = '0;
    for (int i = 0; i < NBYTE; i++)
      acc = acc + WORD'(a[i*BYTE +: BYTE] * b[i*BYTE +: BYTE]);
    return acc;
  endfunction

  function automatic logic [WORD-1:0] f_mul16s(input logic [HALF-1:0] a, input logic [HALF-1:0] b);
    logic signed [WORD-1:0] p;
    p = $signed({{HALF{a[HALF-1]}}, a}) * $signed({{HALF{b[HALF-1]}}, b});
    return p;
  endfunction

  function automatic logic [2*WORD-1:0] f_mul_hw(input logic [HALF-1:0] h, input logic [WORD-1:0] w);
    logic signed [2*WORD-1:0] p;
    p = $signed({{(2*WORD-HALF){h[HALF-1]}}, h}) * $signed({{WORD{w[WORD-1]}}, w});
    return p;
  endfunction

  function automatic logic [WORD-1:0] f_round15(input logic [2*WORD-1:0] p);
    logic [2*WORD-1:0] t;
    t = p + (2*WORD)'(1 << (RND_SH - 1));
    return t[RND_SH +: WORD];
  endfunction

  function automatic logic f_sat_hit(input logic [HALF-1:0] a, input logic [HALF-1:0] b);
    return (a == {1'b1, {(HALF-1){1'b0}}}) && (b == {1'b1, {(HALF-1){1'b0}}});
  endfunction

  function automatic logic [WORD-1:0] f_dbl_sat(input logic [HALF-1:0] a, input logic [HALF-1:0] b);
    logic [WORD-1:0] p;
    p = f_mul16s(a, b);
    if (f_sat_hit(a, b)) return {1'b0, {(WORD-1){1'b1}}};
    return {p[WORD-2:0], 1'b0};
  endfunction

  function automatic logic [HALF-1:0] f_mul8su(input logic [BYTE-1:0] a, input logic [BYTE-1:0] b);
    logic signed [HALF-1:0] p;
    p = $signed({{BYTE{a[BYTE-1]}}, a}) * $signed({{BYTE{1'b0}}, b});
    return p;
  endfunction

  function automatic logic [HALF-1:0] f_mul8u(input logic [BYTE-1:0] a, input logic [BYTE-1:0] b);
    return HALF'(a) * HALF'(b);
  endfunction
endpackage

// File: rtl/simd_mpy_lanes.sv
module simd_mpy_lanes
  import simd_mpy_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [WORD-1:0] a,
  input  logic [WORD-1:0] b,
  output logic [WORD-1:0] hi,
  output logic [WORD-1:0] lo,
  output logic            sat_hi,
  output logic            sat_lo
);
  logic [HALF-1:0]   b8_su [NBYTE];
  logic [HALF-1:0]   b8_u  [NBYTE];
  logic [WORD-1:0]   h16_p [NHALF];
  logic [WORD-1:0]   h16_d [NHALF];
  logic [NHALF-1:0]  h16_sat;
  logic [2*WORD-1:0] hw_up, hw_dn;
  logic [WORD-1:0]   dot;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign b8_su[i] = f_mul8su(a[i*BYTE +: BYTE], b[i*BYTE +: BYTE]);
    assign b8_u[i]  = f_mul8u(a[i*BYTE +: BYTE], b[i*BYTE +: BYTE]);
  end

  for (genvar j = 0; j < NHALF; j++) begin : g_half
    assign h16_p[j]   = f_mul16s(a[j*HALF +: HALF], b[j*HALF +: HALF]);
    assign h16_d[j]   = f_dbl_sat(a[j*HALF +: HALF], b[j*HALF +: HALF]);
    assign h16_sat[j] = f_sat_hit(a[j*HALF +: HALF], b[j*HALF +: HALF]);
  end

  assign hw_up = f_mul_hw(a[WORD-1:HALF], b);
  assign hw_dn = f_mul_hw(a[HALF-1:0], b);
  assign dot   = f_dot4u(a, b);

  assign sat_hi = (op == OP_MUL2DS) && h16_sat[1];
  assign sat_lo = (op == OP_MUL2DS) && h16_sat[0];

  always_comb begin
    hi = '0;
    lo = '0;
    case (op)
      OP_DOT4U:   lo = dot;
      OP_MUL2S:   begin hi = h16_p[1]; lo = h16_p[0]; end
      OP_HWH:     {hi, lo} = hw_up;
      OP_HWL:     {hi, lo} = hw_dn;
      OP_HWH_RND: lo = f_round15(hw_up);
      OP_HWL_RND: lo = f_round15(hw_dn);
      OP_MUL2DS:  begin hi = h16_d[1]; lo = h16_d[0]; end
      OP_MUL4SU:  begin hi = {b8_su[3], b8_su[2]}; lo = {b8_su[1], b8_su[0]}; end
      OP_MUL4U:   begin hi = {b8_u[3], b8_u[2]}; lo = {b8_u[1], b8_u[0]}; end
      default:    begin hi = '0; lo = '0; end
    endcase
  end
endmodule

// File: rtl/simd_mpy_pipe.sv
module simd_mpy_pipe #(
  parameter int LAT = 4,
  parameter int W   = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < LAT; k++) d_q[k] <= '0;
    end else begin
      v_q[0] <= v_in;
      d_q[0] <= v_in ? d_in : '0;
      for (int k = 1; k < LAT; k++) begin
        v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign v_out = v_q[LAT-1];
  assign d_out = d_q[LAT-1];
endmodule

// File: rtl/simd_mpy_unit.sv
module simd_mpy_unit
  import simd_mpy_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_in,
  input  logic [OP_W-1:0] opcode,
  input  logic [WORD-1:0] src1,
  input  logic [WORD-1:0] src2,
  output logic            valid_out,
  output logic [WORD-1:0] res_hi,
  output logic [WORD-1:0] res_lo
);
  localparam int RES_W = 2 * WORD;

  logic [WORD-1:0]  comb_hi, comb_lo;
  logic             sat_hi_evt, sat_lo_evt;
  logic [RES_W-1:0] pipe_q;

  simd_mpy_lanes u_lanes (
    .op(opcode), .a(src1), .b(src2),
    .hi(comb_hi), .lo(comb_lo),
    .sat_hi(sat_hi_evt), .sat_lo(sat_lo_evt)
  );

  simd_mpy_pipe #(.LAT(LATENCY), .W(RES_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .v_in(valid_in), .d_in({comb_hi, comb_lo}),
    .v_out(valid_out), .d_out(pipe_q)
  );

  assign res_hi = pipe_q[RES_W-1:WORD];
  assign res_lo = pipe_q[WORD-1:0];
endmodule

// File: rtl/simd_mpy_chk.sv
module simd_mpy_chk
  import simd_mpy_pkg::*;
#(
  parameter int LAT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_in,
  input logic [OP_W-1:0] opcode,
  input logic            sat_hi_evt,
  input logic            sat_lo_evt,
  input logic            valid_out,
  input logic [WORD-1:0] res_hi,
  input logic [WORD-1:0] res_lo
);
  logic [LAT-1:0]  m_v, m_sh, m_sl;
  logic [OP_W-1:0] m_op [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v <= '0; m_sh <= '0; m_sl <= '0;
      for (int k = 0; k < LAT; k++) m_op[k] <= '0;
    end else begin
      m_v[0]  <= valid_in;
      m_sh[0] <= valid_in && sat_hi_evt;
      m_sl[0] <= valid_in && sat_lo_evt;
      m_op[0] <= opcode;
      for (int k = 1; k < LAT; k++) begin
        m_v[k]  <= m_v[k-1];
        m_sh[k] <= m_sh[k-1];
        m_sl[k] <= m_sl[k-1];
        m_op[k] <= m_op[k-1];
      end
    end
  end

  logic [OP_W-1:0] out_op;
  assign out_op = m_op[LAT-1];

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out == m_v[LAT-1]);

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (res_hi == '0 && res_lo == '0));

  p_dot_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && out_op == OP_DOT4U) |-> res_hi == '0);

  p_hw_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && (out_op == OP_HWH || out_op == OP_HWL)) |->
      res_hi[WORD-1:HALF] == {HALF{res_hi[HALF-1]}});

  p_rnd_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && (out_op == OP_HWH_RND || out_op == OP_HWL_RND)) |-> res_hi == '0);

  p_sat_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && m_sh[LAT-1]) |-> res_hi == {1'b0, {(WORD-1){1'b1}}});

  p_sat_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && m_sl[LAT-1]) |-> res_lo == {1'b0, {(WORD-1){1'b1}}});

  p_unassigned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && out_op > OP_MUL4U) |-> (res_hi == '0 && res_lo == '0));
endmodule

bind simd_mpy_unit simd_mpy_chk #(.LAT(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
  .sat_hi_evt(sat_hi_evt), .sat_lo_evt(sat_lo_evt),
  .valid_out(valid_out), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/tb_simd_mpy_unit.sv
module tb_simd_mpy_unit;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] src1 = '0, src2 = '0;
  logic        valid_out;
  logic [31:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] e_hi [LAT];
  logic [31:0] e_lo [LAT];
  logic        e_v  [LAT];
  string       e_tag[LAT];

  always #5 clk = ~clk;

  simd_mpy_unit #(.LATENCY(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .opcode(opcode),
    .src1(src1), .src2(src2), .valid_out(valid_out),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  // Bench arithmetic, written with native integer types.
  function automatic logic [63:0] ref_calc(input int op, input logic [31:0] a, input logic [31:0] b);
    longint p, r;
    int s;
    logic [31:0] h, l;
    h = 0; l = 0;
    case (op)
      0: begin
        s = 0;
        for (int i = 0; i < 4; i++) s += int'(a[8*i +: 8]) * int'(b[8*i +: 8]);
        l = s;
      end
      1, 6: begin
        for (int j = 0; j < 2; j++) begin
          p = longint'(shortint'(a[16*j +: 16])) * longint'(shortint'(b[16*j +: 16]));
          if (op == 6) begin
            p = p * 2;
            if (p > 64'sd2147483647) p = 64'sd2147483647;
          end
          if (j == 1) h = p[31:0]; else l = p[31:0];
        end
      end
      2, 3, 4, 5: begin
        p = longint'(shortint'((op == 2 || op == 4) ? a[31:16] : a[15:0])) * longint'(int'(b));
        if (op >= 4) begin
          r = (p + 64'sd16384) >>> 15;
          l = r[31:0];
        end else begin
          h = p[63:32]; l = p[31:0];
        end
      end
      7, 8: begin
        for (int i = 0; i < 4; i++) begin
          s = (op == 7) ? int'(byte'(a[8*i +: 8])) * int'(b[8*i +: 8])
                        : int'(a[8*i +: 8]) * int'(b[8*i +: 8]);
          if (i >= 2) h[16*(i-2) +: 16] = s[15:0]; else l[16*i +: 16] = s[15:0];
        end
      end
      default: begin h = 0; l = 0; end
    endcase
    return {h, l};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: compare outputs with the oldest model entry, then issue.
  task automatic step(input logic v, input int op, input logic [31:0] a, input logic [31:0] b,
                      input bit lit, input logic [63:0] lit_val, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    chk("R2", {63'd0, valid_out}, {63'd0, e_v[LAT-1]});
    if (e_v[LAT-1]) chk(e_tag[LAT-1], {res_hi, res_lo}, {e_hi[LAT-1], e_lo[LAT-1]});
    else            chk("R3", {res_hi, res_lo}, 64'd0);
    for (int k = LAT-1; k > 0; k--) begin
      e_v[k] = e_v[k-1]; e_hi[k] = e_hi[k-1]; e_lo[k] = e_lo[k-1]; e_tag[k] = e_tag[k-1];
    end
    exp = lit ? lit_val : ref_calc(op, a, b);
    e_v[0] = v; e_hi[0] = exp[63:32]; e_lo[0] = exp[31:0];
    e_tag[0] = (tag != "") ? tag : tag_of(op);
    valid_in = v; opcode = 4'(op); src1 = a; src2 = b;
  endtask

  function automatic logic [31:0] pick_word();
    logic [31:0] w;
    w = $urandom;
    for (int i = 0; i < 4; i++)
      case ($urandom % 8)
        0: w[8*i +: 8] = 8'h80;
        1: w[8*i +: 8] = 8'h7F;
        2: w[8*i +: 8] = 8'h00;
        3: w[8*i +: 8] = 8'hFF;
        default: ;
      endcase
    if ($urandom % 6 == 0) w[31:16] = 16'h8000;
    if ($urandom % 6 == 0) w[15:0]  = 16'h8000;
    return w;
  endfunction

  initial begin
    for (int k = 0; k < LAT; k++) begin e_v[k] = 0; e_hi[k] = 0; e_lo[k] = 0; e_tag[k] = "R3"; end
    void'($urandom(32'd20240613));
    // R1: stimulus during reset must leave the outputs idle
    valid_in = 1'b1; opcode = 4'd1; src1 = 32'hFFFF_FFFF; src2 = 32'hFFFF_FFFF;
    repeat (6) begin
      @(negedge clk);
      chk("R1", {31'd0, valid_out, res_hi, res_lo} , 64'd0);
    end
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, valid_out, res_hi, res_lo}, 64'd0);

    // Directed corner cases, issued back to back
    step(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 64'h0000_0000_0003_F804, "R4");
    step(1, 1, 32'h6A32_1193, 32'hB174_6CA4, 1, 64'hDF6A_B0A8_0775_462C, "R5");
    step(1, 2, 32'h6A32_1193, 32'hB174_6CA4, 1, 64'hFFFF_DF6A_DDB9_2008, "R6");
    step(1, 4, 32'h1234_3497, 32'h21FF_50A7, 1, 64'h0000_0000_04D5_B710, "R7");
    step(1, 5, 32'h1234_3497, 32'h21FF_50A7, 1, 64'h0000_0000_0DF7_D3F5, "R7");
    step(1, 6, 32'h6A32_1193, 32'hB174_6CA4, 1, 64'hBED5_6150_0EEA_8C58, "R8");
    step(1, 6, 32'h8000_8000, 32'h8000_8000, 1, 64'h7FFF_FFFF_7FFF_FFFF, "R8");
    step(1, 6, 32'h8000_8000, 32'h8000_7FFF, 1, 64'h7FFF_FFFF_8001_0000, "R8");
    step(1, 7, 32'h6A32_1193, 32'hB174_6CA4, 1, 64'h494A_16A8_072C_BA2C, "R9");
    step(1, 8, 32'h6832_C193, 32'hB174_2CAB, 1, 64'h47E8_16A8_212C_6231, "R10");
    step(1, 9, 32'h1234_5678, 32'h9ABC_DEF0, 1, 64'd0, "R11");
    step(0, 1, 32'hFFFF_FFFF, 32'h1111_1111, 1, 64'd0, "R3");
    step(1, 15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 64'd0, "R11");
    step(1, 3, 32'h0000_8000, 32'h8000_0000, 0, 64'd0, "R6");

    // Constrained random stream with gaps in the issue strobe
    for (int n = 0; n < 4000; n++)
      step(($urandom % 4) != 0, int'($urandom % 12), pick_word(), pick_word(), 0, 64'd0, "");
    for (int n = 0; n < LAT + 2; n++)
      step(0, 0, 32'd0, 32'd0, 1, 64'd0, "R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule